// File: doc/BRIEF.md
# Cascaded TDMA Timebase Counters

This block derives the bit, slot and frame timing of a time-division air interface from a single reference tick. A prescaler counts reference ticks. Each time it completes its range, an advance request passes through a short, fixed pipeline of system cycles and then steps the bit counter. The bit counter carries into the slot counter, and the slot counter carries into the frame counter. Every stage wraps at its own range and emits a one-cycle pulse when it returns to zero.

A synchronous load strobe writes all four stages in one cycle. A radio uses it to align its timebase with a peer. The reference tick is a one-cycle enable in the system clock domain. The defaults are 9 reference ticks per bit, 480 bits per slot, 24 slots per frame and 16 frames per super-period. With a 10.368 MHz reference this gives 1.152 Mbit/s and a 10 ms frame.

Top module: `tdma_timebase`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, all four counters read 0 and all four wrap pulses are low.
- R2: On each cycle with `ref_tick` high and `load` low, `pre_cnt` counts 0,1,...,8 and then returns to 0. On cycles with `ref_tick` low it holds its value.
- R3: The bit counter (range 0..479) steps by one exactly 2 system cycles after the clock edge at which `pre_cnt` returns from 8 to 0. Between those steps it holds.
- R4: The slot counter (range 0..23) steps on the same clock edge at which the bit counter wraps from 479 to 0.
- R5: The frame counter (range 0..15) steps on the same edge at which the slot counter wraps from 23 to 0, and wraps from 15 to 0. Starting from all zeros, it reads 1 after exactly 103680 reference ticks and still reads 0 after 103679.
- R6: Each of `pre_wrap`, `bit_wrap`, `slot_wrap` and `frame_wrap` is high for exactly one cycle: the first cycle in which its counter reads 0 after counting past its top value. A load never raises a wrap pulse.
- R7: When `load` is high, all four counters take the supplied load values at that clock edge, whatever `ref_tick` is. Any bit step still in the 2-cycle pipeline is discarded.
- R8: A load value that is not below its counter's range (prescaler 9, bit 480, slot 24, frame 16) loads 0 into that counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle reference tick enable |
| load | input | 1 | Load strobe for all counters |
| load_pre | input | 4 | Prescaler load value |
| load_bit | input | 9 | Bit counter load value |
| load_slot | input | 5 | Slot counter load value |
| load_frame | input | 4 | Frame counter load value |
| pre_cnt | output | 4 | Reference ticks within the current bit |
| bit_cnt | output | 9 | Bit index within the slot |
| slot_cnt | output | 5 | Slot index within the frame |
| frame_cnt | output | 4 | Frame index within the super-period |
| pre_wrap | output | 1 | Prescaler returned to 0 |
| bit_wrap | output | 1 | Bit counter returned to 0 |
| slot_wrap | output | 1 | Slot counter returned to 0 |
| frame_wrap | output | 1 | Frame counter returned to 0 |

## Verification
Assertions check on every cycle that each counter stays in its range and holds when it is not stepped. They also check that a load lands with out-of-range values reduced to zero, that each wrap pulse lasts one cycle and coincides with a zero count, and that a slot or frame change happens only as a carry from the stage below. Only the bench scenarios can show the absolute positions. These are the exact two-cycle lag between a prescaler wrap and the bit step, the discarding of a pipelined step by a load, and the correct number of wraps over long random runs of reference ticks. They also include the full 103680-tick frame count from reset.

// File: rtl/tbase_pkg.sv
// Package: shared defaults and width helper for the TDMA timebase.
// Assumes every range is at least 2.
package tbase_pkg;
    localparam int DEF_REF_PER_BIT    = 9;
    localparam int DEF_BITS_PER_SLOT  = 480;
    localparam int DEF_SLOTS_PER_FRM  = 24;
    localparam int DEF_FRMS_PER_SUPER = 16;
    localparam int DEF_STEP_LAG       = 2;

    // Bits needed to hold values 0..n-1.
    function automatic int cnt_w(input int n);
        return (n > 2) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/tbase_wrap_counter.sv
// Module: modulo counter with step enable, synchronous load and a
// registered wrap pulse. Assumes RANGE >= 2 and RANGE <= 2**W.
// An out-of-range load value loads 0.
module tbase_wrap_counter #(
    parameter int RANGE = 9,
    parameter int W     = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         carry,
    output logic         wrap_pulse
);
    localparam logic [W:0]   RANGE_X = (W+1)'(RANGE);
    localparam logic [W-1:0] TOP     = W'(RANGE - 1);

    logic at_top;
    logic load_ok;

    // Decode top value and load legality.
    always_comb begin
        at_top  = (cnt == TOP);
        load_ok = ({1'b0, load_val} < RANGE_X);
        carry   = step && at_top && !load;
    end

    // Count, load, and register the wrap pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            wrap_pulse <= 1'b0;
        end else if (load) begin
            cnt        <= load_ok ? load_val : '0;
            wrap_pulse <= 1'b0;
        end else if (step) begin
            cnt        <= at_top ? '0 : cnt + W'(1);
            wrap_pulse <= at_top;
        end else begin
            wrap_pulse <= 1'b0;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt} < RANGE_X));                                              // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> (cnt == $past(cnt)));                             // R2
    AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == (({1'b0, $past(load_val)} < RANGE_X) ? $past(load_val) : '0))); // R8
    AST_LOAD_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !wrap_pulse);                                                 // R6
    AST_PULSE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |-> (cnt == '0));                                           // R6
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |=> !wrap_pulse);                                           // R6
endmodule

// File: rtl/tbase_step_lag.sv
// Module: fixed pipeline of LAG system cycles between the prescaler
// terminal pulse and the bit step. LAG = 0 is a plain wire. A clear
// empties the pipeline, discarding steps in flight.
module tbase_step_lag #(
    parameter int LAG = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic pulse_in,
    output logic pulse_out
);
    generate
        if (LAG == 0) begin : g_wire
            // No lag: pass straight through.
            assign pulse_out = pulse_in;
        end else if (LAG == 1) begin : g_one
            logic stage;
            // Single register stage.
            always_ff @(posedge clk) begin
                if (!rst_n || clear) stage <= 1'b0;
                else                 stage <= pulse_in;
            end
            assign pulse_out = stage;
        end else begin : g_many
            logic [LAG-1:0] stages;
            // Shift register of LAG stages.
            always_ff @(posedge clk) begin
                if (!rst_n || clear) stages <= '0;
                else                 stages <= {stages[LAG-2:0], pulse_in};
            end
            assign pulse_out = stages[LAG-1];
        end
    endgenerate
endmodule

// File: rtl/tdma_timebase.sv
// Module: cascaded prescaler / bit / slot / frame timebase for a TDMA
// air interface. Assumes ref_tick is a one-cycle enable in the clk
// domain. Load overrides counting and flushes the step pipeline.
module tdma_timebase
    import tbase_pkg::*;
#(
    parameter int REF_PER_BIT    = DEF_REF_PER_BIT,
    parameter int BITS_PER_SLOT  = DEF_BITS_PER_SLOT,
    parameter int SLOTS_PER_FRM  = DEF_SLOTS_PER_FRM,
    parameter int FRMS_PER_SUPER = DEF_FRMS_PER_SUPER,
    parameter int STEP_LAG       = DEF_STEP_LAG,
    localparam int PW = cnt_w(REF_PER_BIT),
    localparam int BW = cnt_w(BITS_PER_SLOT),
    localparam int SW = cnt_w(SLOTS_PER_FRM),
    localparam int FW = cnt_w(FRMS_PER_SUPER)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_tick,
    input  logic          load,
    input  logic [PW-1:0] load_pre,
    input  logic [BW-1:0] load_bit,
    input  logic [SW-1:0] load_slot,
    input  logic [FW-1:0] load_frame,
    output logic [PW-1:0] pre_cnt,
    output logic [BW-1:0] bit_cnt,
    output logic [SW-1:0] slot_cnt,
    output logic [FW-1:0] frame_cnt,
    output logic          pre_wrap,
    output logic          bit_wrap,
    output logic          slot_wrap,
    output logic          frame_wrap
);
    logic pre_carry, bit_step, bit_carry, slot_carry, frame_carry;

    tbase_wrap_counter #(.RANGE(REF_PER_BIT), .W(PW)) u_pre (
        .clk(clk), .rst_n(rst_n), .step(ref_tick), .load(load),
        .load_val(load_pre), .cnt(pre_cnt), .carry(pre_carry),
        .wrap_pulse(pre_wrap));

    tbase_step_lag #(.LAG(STEP_LAG)) u_lag (
        .clk(clk), .rst_n(rst_n), .clear(load),
        .pulse_in(pre_carry), .pulse_out(bit_step));

    tbase_wrap_counter #(.RANGE(BITS_PER_SLOT), .W(BW)) u_bit (
        .clk(clk), .rst_n(rst_n), .step(bit_step), .load(load),
        .load_val(load_bit), .cnt(bit_cnt), .carry(bit_carry),
        .wrap_pulse(bit_wrap));

    tbase_wrap_counter #(.RANGE(SLOTS_PER_FRM), .W(SW)) u_slot (
        .clk(clk), .rst_n(rst_n), .step(bit_carry), .load(load),
        .load_val(load_slot), .cnt(slot_cnt), .carry(slot_carry),
        .wrap_pulse(slot_wrap));

    tbase_wrap_counter #(.RANGE(FRMS_PER_SUPER), .W(FW)) u_frame (
        .clk(clk), .rst_n(rst_n), .step(slot_carry), .load(load),
        .load_val(load_frame), .cnt(frame_cnt), .carry(frame_carry),
        .wrap_pulse(frame_wrap));

    AST_SLOT_BY_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && slot_cnt != $past(slot_cnt)) |->
        (bit_cnt == '0 && $past(bit_cnt) == BW'(BITS_PER_SLOT - 1)));         // R4
    AST_FRAME_BY_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && frame_cnt != $past(frame_cnt)) |->
        (slot_cnt == '0 && $past(slot_cnt) == SW'(SLOTS_PER_FRM - 1)));        // R5
    AST_SUPER_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        frame_carry |=> (frame_cnt == '0 && slot_cnt == '0 && bit_cnt == '0)); // R5
    AST_BIT_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !bit_step) |=> (bit_cnt == $past(bit_cnt)));                 // R3
endmodule

// File: tb/sim_tdma_timebase.sv
module sim_tdma_timebase;
    localparam int RPB = 9, BPS = 480, SPF = 24, FPS = 16, LAG = 2;
    localparam longint T_SLOT  = RPB * BPS;
    localparam longint T_FRAME = T_SLOT * SPF;
    localparam longint T_SUPER = T_FRAME * FPS;

    logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0, load = 1'b0;
    logic [3:0] load_pre = '0;
    logic [8:0] load_bit = '0;
    logic [4:0] load_slot = '0;
    logic [3:0] load_frame = '0;
    logic [3:0] pre_cnt;
    logic [8:0] bit_cnt;
    logic [4:0] slot_cnt;
    logic [3:0] frame_cnt;
    logic pre_wrap, bit_wrap, slot_wrap, frame_wrap;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;
    longint np = 0, nb = 0, ns = 0, nf = 0;
    logic [3:0] prev_p = '0;

    always #5 clk = ~clk;

    tdma_timebase u0 (.*);

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected counter values from a total tick position.
    function automatic longint f_pre(input longint t);   return t % RPB; endfunction
    function automatic longint f_bit(input longint t);   return (t / RPB) % BPS; endfunction
    function automatic longint f_slot(input longint t);  return (t / T_SLOT) % SPF; endfunction
    function automatic longint f_frame(input longint t); return (t / T_FRAME) % FPS; endfunction
    function automatic longint clampv(input longint v, input longint r); return (v < r) ? v : 0; endfunction

    // Pulse monitor: every pulse sits on a zero count and lasts one cycle (R6).
    always @(negedge clk) begin
        if (rst_n) begin
            if (pre_wrap)   begin np++; chk(pre_cnt == 0,   "R6 pre pulse at zero",   pre_cnt, 0); end
            if (bit_wrap)   begin nb++; chk(bit_cnt == 0,   "R6 bit pulse at zero",   bit_cnt, 0); end
            if (slot_wrap)  begin ns++; chk(slot_cnt == 0,  "R6 slot pulse at zero",  slot_cnt, 0); end
            if (frame_wrap) begin nf++; chk(frame_cnt == 0, "R6 frame pulse at zero", frame_cnt, 0); end
            if (|(prev_p & {pre_wrap, bit_wrap, slot_wrap, frame_wrap}))
                chk(1'b0, "R6 pulse longer than one cycle", 2, 1);
        end
        prev_p = {pre_wrap, bit_wrap, slot_wrap, frame_wrap};
    end

    task automatic step(input logic t);
        ref_tick = t;
        @(posedge clk); #1;
        ref_tick = 1'b0;
    endtask

    task automatic do_load(input int p, input int b, input int s, input int f, input logic t);
        load_pre = 4'(p); load_bit = 9'(b); load_slot = 5'(s); load_frame = 4'(f);
        load = 1'b1; ref_tick = t;
        @(posedge clk); #1;
        load = 1'b0; ref_tick = 1'b0;
    endtask

    task automatic check_pos(input longint t, input string tag);
        chk(pre_cnt == 4'(f_pre(t)),     {tag, " pre"},   pre_cnt,   f_pre(t));
        chk(bit_cnt == 9'(f_bit(t)),     {tag, " bit"},   bit_cnt,   f_bit(t));
        chk(slot_cnt == 5'(f_slot(t)),   {tag, " slot"},  slot_cnt,  f_slot(t));
        chk(frame_cnt == 4'(f_frame(t)), {tag, " frame"}, frame_cnt, f_frame(t));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        longint base, t1, sp, sb, ss, sf;
        int n;
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check_pos(0, "R1 in reset");
        rst_n = 1'b1;
        step(1'b0);
        check_pos(0, "R1 after reset");
        chk({pre_wrap, bit_wrap, slot_wrap, frame_wrap} == 4'b0, "R1 pulses low", 1, 0);

        // R2: idle cycles hold, ticks count
        repeat (5) step(1'b0);
        chk(pre_cnt == 0, "R2 hold without tick", pre_cnt, 0);
        repeat (4) step(1'b1);
        chk(pre_cnt == 4, "R2 four ticks", pre_cnt, 4);

        // R7: load beats a simultaneous tick
        do_load(8, 5, 3, 2, 1'b1);
        chk(pre_cnt == 8 && bit_cnt == 5, "R7 load priority", pre_cnt, 8);
        chk(slot_cnt == 3 && frame_cnt == 2, "R7 load slot/frame", slot_cnt, 3);
        // R3: bit steps exactly LAG cycles after prescaler wrap
        step(1'b1);
        chk(pre_cnt == 0 && pre_wrap, "R2 prescaler wrap pulse", pre_cnt, 0);
        chk(bit_cnt == 5, "R3 no step at wrap edge", bit_cnt, 5);
        step(1'b0);
        chk(bit_cnt == 5, "R3 no step one cycle later", bit_cnt, 5);
        step(1'b0);
        chk(bit_cnt == 6, "R3 step after two cycles", bit_cnt, 6);

        // R7: load discards a step in flight
        do_load(8, 7, 0, 0, 1'b0);
        step(1'b1);
        do_load(3, 100, 0, 0, 1'b0);
        repeat (4) step(1'b0);
        chk(bit_cnt == 100, "R7 pending step dropped", bit_cnt, 100);

        // R8: out-of-range loads become 0
        do_load(12, 500, 30, 7, 1'b0);
        chk(pre_cnt == 0 && bit_cnt == 0, "R8 pre/bit clamp", bit_cnt, 0);
        chk(slot_cnt == 0 && frame_cnt == 7, "R8 slot clamp", slot_cnt, 0);

        // R6: load never raises a pulse
        do_load(0, 0, 0, 0, 1'b0);
        chk({pre_wrap, bit_wrap, slot_wrap, frame_wrap} == 4'b0, "R6 no pulse on load", 1, 0);

        // R4/R5/R6: directed full roll-over of the whole chain
        do_load(8, 479, 23, 15, 1'b0);
        sb = nb; ss = ns; sf = nf;
        step(1'b1);
        repeat (LAG + 2) step(1'b0);
        check_pos(0, "R5 super roll-over");
        chk(nb - sb == 1 && ns - ss == 1 && nf - sf == 1, "R6 one pulse each on roll-over", nf - sf, 1);

        // Random segments: load near boundaries, random tick bursts (R2-R6, R8)
        for (int it = 0; it < 30; it++) begin
            int lp, lb, ls, lf;
            lp = $urandom % 12;
            lb = ($urandom % 2) ? 460 + $urandom % 20 : $urandom % 512;
            ls = 20 + $urandom % 8;
            lf = ($urandom % 2) ? 15 : $urandom % 16;
            do_load(lp, lb, ls, lf, 1'(($urandom % 2)));
            base = ((clampv(lf, FPS) * SPF + clampv(ls, SPF)) * BPS + clampv(lb, BPS)) * RPB + clampv(lp, RPB);
            sp = np; sb = nb; ss = ns; sf = nf;
            n = 0;
            for (int c = 0; c < 200 + int'($urandom % 400); c++) begin
                logic tk;
                tk = ($urandom % 4) != 0;
                if (tk) n++;
                step(tk);
            end
            repeat (LAG + 2) step(1'b0);
            t1 = base + n;
            check_pos(t1, "R4/R5 random segment");
            chk(np - sp == t1 / RPB - base / RPB, "R2 prescaler wrap count", np - sp, t1 / RPB - base / RPB);
            chk(nb - sb == t1 / T_SLOT - base / T_SLOT, "R4 bit wrap count", nb - sb, t1 / T_SLOT - base / T_SLOT);
            chk(ns - ss == t1 / T_FRAME - base / T_FRAME, "R5 slot wrap count", ns - ss, t1 / T_FRAME - base / T_FRAME);
            chk(nf - sf == t1 / T_SUPER - base / T_SUPER, "R6 frame wrap count", nf - sf, t1 / T_SUPER - base / T_SUPER);
        end

        // R5: a whole frame of reference ticks from zero
        do_load(0, 0, 0, 0, 1'b0);
        ref_tick = 1'b1;
        repeat (103679) @(posedge clk);
        #1;
        ref_tick = 1'b0;
        repeat (LAG + 2) step(1'b0);
        check_pos(103679, "R5 one tick short of a frame");
        step(1'b1);
        repeat (LAG + 2) step(1'b0);
        check_pos(103680, "R5 full frame");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule